// File: doc/BRIEF.md
# CAN Error-Limit Interrupt Monitor

This block watches the transmit and receive error counters of a CAN controller and reports when either of them reaches a limit that software selects. A single control bit picks the limit. When the bit is 0 the limit is 96 errors, and when it is 1 the limit is 128 errors. The block compares both counters against the limit every clock and holds the result in a registered "limit exceeded" status flag.

The block turns changes of that flag into a one-clock interrupt request pulse. A request is issued only when three enables are all set: a local error-interrupt enable, a module-level interrupt enable and a global interrupt enable. In the 96 mode only the flag's clear-to-set transition raises a request. In the 128 mode both the clear-to-set and the set-to-clear transitions raise one, so software also learns when the controller has recovered below the limit. The error counting itself and the processor's interrupt controller sit outside the block.

Top module: `can_err_limit_mon`

## Requirements
- R1: With limitSel = 0 the threshold is 96. A counter value of 96 or more sets the flag, and values of 95 or less on both counters leave it clear.
- R2: With limitSel = 1 the threshold is 128. A counter value of 128 or more sets the flag, and values of 127 or less on both counters leave it clear.
- R3: Either counter alone reaching the selected threshold sets the flag, whatever the other counter holds.
- R4: The flag is a register. In every cycle it shows the comparison made on the counter and select values present at the previous rising clock edge, and it clears as soon as both counters are below the threshold.
- R5: No interrupt request is issued unless errIntEn, modIntEn and globIntEn are all 1 at the clock edge that registers the request.
- R6: With limitSel = 1, a request is issued after the flag goes from clear to set and also after it goes from set to clear.
- R7: With limitSel = 0, a request is issued only after a clear-to-set change of the flag. A set-to-clear change raises none.
- R8: The request is a pulse of exactly one clock. It is high in the cycle after the cycle in which the flag changed.
- R9: A synchronous active-high reset clears the flag and the edge history. No request is issued in the cycle after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txErrCnt | input | 8 | Transmit error counter value |
| rxErrCnt | input | 8 | Receive error counter value |
| limitSel | input | 1 | Threshold select: 0 gives 96, 1 gives 128 |
| errIntEn | input | 1 | Local error-interrupt enable |
| modIntEn | input | 1 | Module interrupt enable |
| globIntEn | input | 1 | Global interrupt enable |
| errLimitFlag | output | 1 | Registered "limit exceeded" status flag |
| errIrq | output | 1 | One-clock interrupt request pulse |

## Verification
Directed steps place each counter in turn exactly on its threshold and one below it, in both select modes. This separates a greater-or-equal comparison from a strict one and shows whether the wrong limit is in use. Directed sequences then raise and drop the flag with all enables set and with each enable cleared in turn. These show whether the falling edge is honoured only in the 128 mode and whether any single enable is left out of the gating. Random stimulus biased around 96 and 128, with random enables, mode flips and occasional resets, checks every cycle of both outputs against a cycle model. This exposes timing slips in the flag or the pulse and requests that appear after reset.

// File: rtl/can_err_limit_pkg.sv
package can_err_limit_pkg;

  // Edge events reported by the datapath to the control
  typedef struct packed {
    logic rise;
    logic fall;
  } flagEdge_t;

  // Strobes driven by the control into the datapath
  typedef struct packed {
    logic selHigh;   // compare against the high threshold
    logic clearHist; // clear flag and edge history
  } ctlStrobe_t;

endpackage

// File: rtl/can_err_limit_dp.sv
module can_err_limit_dp
  import can_err_limit_pkg::*;
#(
  parameter int CntWidth  = 8,
  parameter int LimitLow  = 96,
  parameter int LimitHigh = 128
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CntWidth-1:0] txCnt,
  input  logic [CntWidth-1:0] rxCnt,
  input  ctlStrobe_t          strobe,
  output logic                flag,
  output flagEdge_t           edgeEvt
);

  localparam logic [CntWidth-1:0] LimLo = CntWidth'(LimitLow);
  localparam logic [CntWidth-1:0] LimHi = CntWidth'(LimitHigh);

  logic [CntWidth-1:0] limit;
  logic                txOver;
  logic                rxOver;
  logic                prevFlag;

  assign limit  = strobe.selHigh ? LimHi : LimLo;
  assign txOver = txCnt >= limit;
  assign rxOver = rxCnt >= limit;

  always_ff @(posedge clk) begin
    if (rst || strobe.clearHist) begin
      flag     <= 1'b0;
      prevFlag <= 1'b0;
    end else begin
      flag     <= txOver | rxOver;
      prevFlag <= flag;
    end
  end

  assign edgeEvt.rise = flag & ~prevFlag;
  assign edgeEvt.fall = ~flag & prevFlag;

  // R3
  high_limit_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (txCnt >= LimHi || rxCnt >= LimHi) |=> flag);

  // R1
  below_low_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (txCnt < LimLo && rxCnt < LimLo) |=> !flag);

  // R2
  below_high_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.selHigh && txCnt < LimHi && rxCnt < LimHi) |=> !flag);

endmodule

// File: rtl/can_err_limit_ctl.sv
module can_err_limit_ctl
  import can_err_limit_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       limitSel,
  input  logic       errIntEn,
  input  logic       modIntEn,
  input  logic       globIntEn,
  input  flagEdge_t  edgeEvt,
  output ctlStrobe_t strobe,
  output logic       irq
);

  logic enAll;
  logic irqEvent;

  assign strobe.selHigh   = limitSel;
  assign strobe.clearHist = 1'b0;

  assign enAll    = errIntEn & modIntEn & globIntEn;
  assign irqEvent = edgeEvt.rise | (limitSel & edgeEvt.fall);

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= enAll & irqEvent;
  end

  // R5
  enable_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !(errIntEn && modIntEn && globIntEn) |=> !irq);

  // R7
  low_mode_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (!limitSel && edgeEvt.fall && !edgeEvt.rise) |=> !irq);

endmodule

// File: rtl/can_err_limit_mon.sv
module can_err_limit_mon
  import can_err_limit_pkg::*;
#(
  parameter int CntWidth  = 8,
  parameter int LimitLow  = 96,
  parameter int LimitHigh = 128
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CntWidth-1:0] txErrCnt,
  input  logic [CntWidth-1:0] rxErrCnt,
  input  logic                limitSel,
  input  logic                errIntEn,
  input  logic                modIntEn,
  input  logic                globIntEn,
  output logic                errLimitFlag,
  output logic                errIrq
);

  ctlStrobe_t strobe;
  flagEdge_t  edgeEvt;

  can_err_limit_dp #(
    .CntWidth (CntWidth),
    .LimitLow (LimitLow),
    .LimitHigh(LimitHigh)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .txCnt  (txErrCnt),
    .rxCnt  (rxErrCnt),
    .strobe (strobe),
    .flag   (errLimitFlag),
    .edgeEvt(edgeEvt)
  );

  can_err_limit_ctl u_ctl (
    .clk      (clk),
    .rst      (rst),
    .limitSel (limitSel),
    .errIntEn (errIntEn),
    .modIntEn (modIntEn),
    .globIntEn(globIntEn),
    .edgeEvt  (edgeEvt),
    .strobe   (strobe),
    .irq      (errIrq)
  );

  // R8
  irq_follows_change_chk: assert property (@(posedge clk) disable iff (rst)
    errIrq |-> ($past(errLimitFlag) != $past(errLimitFlag, 2)));

  // R9
  no_irq_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !errIrq);

endmodule

// File: tb/can_err_limit_mon_bench.sv
`timescale 1ns/1ps
module can_err_limit_mon_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] txErrCnt = '0;
  logic [7:0] rxErrCnt = '0;
  logic       limitSel = 1'b0;
  logic       errIntEn = 1'b0;
  logic       modIntEn = 1'b0;
  logic       globIntEn = 1'b0;
  logic       errLimitFlag;
  logic       errIrq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // cycle model state
  logic mFlag = 1'b0;
  logic mPrev = 1'b0;
  logic mIrq  = 1'b0;

  always #2.5 clk = ~clk;

  can_err_limit_mon u_can_err_limit_mon (
    .clk(clk), .rst(rst), .txErrCnt(txErrCnt), .rxErrCnt(rxErrCnt),
    .limitSel(limitSel), .errIntEn(errIntEn), .modIntEn(modIntEn),
    .globIntEn(globIntEn), .errLimitFlag(errLimitFlag), .errIrq(errIrq)
  );

  function automatic int expLimit(logic sel);
    return sel ? 128 : 96;
  endfunction

  function automatic logic expOver(logic [7:0] tx, logic [7:0] rx, logic sel);
    return (int'(tx) >= expLimit(sel)) || (int'(rx) >= expLimit(sel));
  endfunction

  function automatic logic expIrq(logic f, logic p, logic sel, logic en);
    return en && ((f && !p) || (sel && !f && p));
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mFlag <= 1'b0; mPrev <= 1'b0; mIrq <= 1'b0;
    end else begin
      mIrq  <= expIrq(mFlag, mPrev, limitSel, errIntEn & modIntEn & globIntEn);
      mPrev <= mFlag;
      mFlag <= expOver(txErrCnt, rxErrCnt, limitSel);
    end
  end

  task automatic checkVal(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic checkBoth(string tag);
    checkVal(tag, "flag", errLimitFlag, mFlag);
    checkVal(tag, "irq", errIrq, mIrq);
  endtask

  // drive at negedge, pass one rising edge, compare at next negedge
  task automatic step(logic [7:0] tx, logic [7:0] rx, logic sel, logic [2:0] en, string tag);
    txErrCnt = tx; rxErrCnt = rx; limitSel = sel;
    {errIntEn, modIntEn, globIntEn} = en;
    @(negedge clk);
    checkBoth(tag);
  endtask

  task automatic doReset();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    @(negedge clk);
    doReset();
    // R9: reset state and the cycle after reset
    checkVal("R9", "flag after reset", errLimitFlag, 1'b0);
    checkVal("R9", "irq after reset", errIrq, 1'b0);
    step(8'd0, 8'd0, 1'b0, 3'b111, "R9");

    // R1: low threshold boundary on tx
    step(8'd95, 8'd0, 1'b0, 3'b111, "R1");
    checkVal("R1", "flag at 95", errLimitFlag, 1'b0);
    step(8'd96, 8'd0, 1'b0, 3'b111, "R1");
    checkVal("R1", "flag at 96", errLimitFlag, 1'b1);
    // R8: pulse one cycle after change, then gone
    step(8'd96, 8'd0, 1'b0, 3'b111, "R8");
    checkVal("R8", "irq after rise", errIrq, 1'b1);
    step(8'd96, 8'd0, 1'b0, 3'b111, "R8");
    checkVal("R8", "irq second cycle", errIrq, 1'b0);
    // R7: fall in low mode raises no request
    step(8'd10, 8'd0, 1'b0, 3'b111, "R7");
    checkVal("R4", "flag clears", errLimitFlag, 1'b0);
    step(8'd10, 8'd0, 1'b0, 3'b111, "R7");
    checkVal("R7", "no irq on fall", errIrq, 1'b0);

    // R3: rx alone; R2: high threshold
    step(8'd0, 8'd127, 1'b1, 3'b111, "R2");
    checkVal("R2", "flag at 127", errLimitFlag, 1'b0);
    step(8'd0, 8'd128, 1'b1, 3'b111, "R3");
    checkVal("R3", "rx alone sets", errLimitFlag, 1'b1);
    step(8'd0, 8'd128, 1'b1, 3'b111, "R6");
    checkVal("R6", "irq on rise", errIrq, 1'b1);
    step(8'd100, 8'd0, 1'b1, 3'b111, "R6");
    checkVal("R2", "100 below high", errLimitFlag, 1'b0);
    step(8'd100, 8'd0, 1'b1, 3'b111, "R6");
    checkVal("R6", "irq on fall", errIrq, 1'b1);
    step(8'd100, 8'd0, 1'b1, 3'b111, "R8");
    checkVal("R8", "pulse ends", errIrq, 1'b0);

    // R5: each enable cleared in turn
    for (int k = 0; k < 3; k++) begin
      logic [2:0] en;
      en = 3'b111 & ~(3'b001 << k);
      step(8'd0, 8'd0, 1'b1, en, "R5");
      step(8'd200, 8'd0, 1'b1, en, "R5");
      step(8'd200, 8'd0, 1'b1, en, "R5");
      checkVal("R5", "gated rise", errIrq, 1'b0);
      step(8'd0, 8'd0, 1'b1, en, "R5");
      step(8'd0, 8'd0, 1'b1, en, "R5");
      checkVal("R5", "gated fall", errIrq, 1'b0);
    end

    // R9: reset while flag set, no request follows
    step(8'd255, 8'd255, 1'b0, 3'b111, "R9");
    doReset();
    checkVal("R9", "flag cleared by reset", errLimitFlag, 1'b0);
    checkVal("R9", "no irq after reset", errIrq, 1'b0);

    // random phase, counters biased around the thresholds
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] tx, rx;
      logic [2:0] en;
      logic sel;
      case ($urandom_range(0, 3))
        0: tx = 8'($urandom_range(0, 255));
        1: tx = 8'($urandom_range(90, 100));
        2: tx = 8'($urandom_range(122, 134));
        default: tx = 8'($urandom_range(0, 20));
      endcase
      case ($urandom_range(0, 3))
        0: rx = 8'($urandom_range(0, 255));
        1: rx = 8'($urandom_range(90, 100));
        2: rx = 8'($urandom_range(122, 134));
        default: rx = 8'($urandom_range(0, 20));
      endcase
      sel = ($urandom_range(0, 7) == 0) ? ~limitSel : limitSel;
      en  = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 7)) : 3'b111;
      if ($urandom_range(0, 199) == 0) begin
        rst = 1'b1;
        step(tx, rx, sel, en, "R9");
        rst = 1'b0;
      end else begin
        step(tx, rx, sel, en, sel ? "R6" : "R7");
      end
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule